// File: doc/BRIEF.md
# Byte-to-Word Bridge Register

This block is a 16-bit holding register that sits between a narrow 8-bit data bus and a wide 16-bit address bus. A value on the wide bus can be captured in a single clock edge. Alternatively, the register can be filled one byte at a time from the narrow bus, or read back one byte at a time onto it. This lets a 16-bit quantity cross the 8-bit bus in two steps, low byte first.

The register is split into two independently controlled 8-bit lanes. Each lane has its own active-high write strobe and its own active-low read enable. The shared narrow-bus output is a multiplexed byte with a drive flag. The drive flag stands in for a tri-state buffer: when it is low, the block is not driving the bus. Reading both lanes at once is a protocol violation, and the block reports it on a flag.

A sequencer elsewhere issues the strobes. Driving the register back onto the wide bus is handled outside this block.

Top module: `byte_word_bridge`

## Requirements
- R1: While rst_ni is low the register is held at zero, and a lane read after release returns 0x00 for both lanes.
- R2: When word_load_ni is low at a rising clock edge, all 16 bits of word_i are captured in that one edge.
- R3: With word_load_ni high, wr_lo_i high at an edge captures byte_i into bits 7:0 and leaves bits 15:8 unchanged.
- R4: With word_load_ni high, wr_hi_i high at an edge captures byte_i into bits 15:8 and leaves bits 7:0 unchanged.
- R5: With only rd_lo_ni low, byte_o equals bits 7:0 and byte_oe_o is 1, combinationally in the same cycle.
- R6: With only rd_hi_ni low, byte_o equals bits 15:8 and byte_oe_o is 1, combinationally in the same cycle.
- R7: With both read enables high, byte_oe_o is 0, byte_o is 0x00 and rd_conflict_o is 0.
- R8: With both read enables low, rd_conflict_o is 1, byte_oe_o is 0 and byte_o is forced to 0x00.
- R9: If word_load_ni is low in the same cycle as either byte write strobe, the full-width load wins and the byte strobes have no effect.
- R10: With no load and no write strobe, the register keeps its value across edges, whatever byte_i and word_i carry.
- R11: Writing the low byte and then the high byte on two successive edges assembles the 16-bit word. Reading low then high on two cycles returns it in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_load_ni | input | 1 | Full-width load from word_i, active low |
| word_i | input | 16 | Wide-bus value |
| wr_lo_i | input | 1 | Write byte_i into bits 7:0 |
| wr_hi_i | input | 1 | Write byte_i into bits 15:8 |
| byte_i | input | 8 | Narrow-bus input byte |
| rd_lo_ni | input | 1 | Drive bits 7:0 onto narrow bus, active low |
| rd_hi_ni | input | 1 | Drive bits 15:8 onto narrow bus, active low |
| byte_o | output | 8 | Narrow-bus output byte |
| byte_oe_o | output | 1 | Narrow bus is being driven |
| rd_conflict_o | output | 1 | Both read enables asserted together |

## Verification
The register state is visible only through the byte reads. A corrupted lane therefore shows up on byte_o at the first read of that lane after the faulty edge, within one or two cycles of the write under test. Because of this, every write in the sweeps is followed at once by a read of both lanes. A lane that was disturbed when it should have held, or that missed its own write, shows a byte different from the value the bench computed arithmetically. A faulty read decode shows up in the same cycle as a wrong drive flag, a wrong conflict flag or a nonzero byte where the bus must be released.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned LANES      = 2;
  localparam int unsigned LANE_LO    = 0;
  localparam int unsigned LANE_HI    = 1;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/bridge_lane.sv
module bridge_lane #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic [BYTE_W-1:0] q_o
);
  logic [BYTE_W-1:0] q_d, q_q;

  // full-width load takes priority over the byte strobe
  always_comb begin
    q_d = q_q;
    if (load_i)    q_d = load_byte_i;
    else if (wr_i) q_d = wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  a_r9_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(load_byte_i));
  a_r3_lane_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && wr_i) |=> q_o == $past(wr_byte_i));
  a_r10_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !wr_i) |=> $stable(q_o));
endmodule

// File: rtl/bridge_rd_mux.sv
module bridge_rd_mux
  import bridge_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [LANES-1:0][BYTE_W-1:0] lane_q_i,
  input  lane_mask_t                   rd_en_i,
  output logic [BYTE_W-1:0]            byte_o,
  output logic                         oe_o,
  output logic                         conflict_o
);
  logic [BYTE_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < int'(LANES); i++)
      if (rd_en_i[i]) sel = sel | lane_q_i[i];
  end

  always_comb begin
    conflict_o = ($countones(rd_en_i) > 1);
    oe_o       = (rd_en_i != '0) && !conflict_o;
    byte_o     = oe_o ? sel : '0;
  end

  always_comb begin
    a_r8_conflict_quiet: assert (!conflict_o || (!oe_o && byte_o == '0));
    a_r7_released: assert (rd_en_i != '0 || (!oe_o && byte_o == '0 && !conflict_o));
    a_r5_single_drive: assert (!oe_o || $onehot(rd_en_i));
  end
endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
  import bridge_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  localparam int unsigned WORD_W = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_load_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_lo_ni,
  input  logic              rd_hi_ni,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_oe_o,
  output logic              rd_conflict_o
);
  lane_mask_t wr_mask, rd_mask;
  logic [LANES-1:0][BYTE_W-1:0] lane_q;
  logic load;

  assign load = !word_load_ni;

  always_comb begin
    wr_mask = '0;
    rd_mask = '0;
    wr_mask[LANE_LO] = wr_lo_i;
    wr_mask[LANE_HI] = wr_hi_i;
    rd_mask[LANE_LO] = !rd_lo_ni;
    rd_mask[LANE_HI] = !rd_hi_ni;
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    bridge_lane #(.BYTE_W(BYTE_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_byte_i(word_i[g*BYTE_W +: BYTE_W]),
      .wr_i       (wr_mask[g]),
      .wr_byte_i  (byte_i),
      .q_o        (lane_q[g])
    );
  end

  bridge_rd_mux #(.BYTE_W(BYTE_W)) u_rd_mux (
    .lane_q_i  (lane_q),
    .rd_en_i   (rd_mask),
    .byte_o    (byte_o),
    .oe_o      (byte_oe_o),
    .conflict_o(rd_conflict_o)
  );

  a_r2_word_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_load_ni |=> lane_q == $past(word_i));
  a_r4_hi_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_load_ni && wr_hi_i && !wr_lo_i) |=> lane_q[LANE_LO] == $past(lane_q[LANE_LO]));
  a_r3_lo_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_load_ni && wr_lo_i && !wr_hi_i) |=> lane_q[LANE_HI] == $past(lane_q[LANE_HI]));
  a_r6_hi_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_hi_ni && rd_lo_ni) |-> (byte_oe_o && byte_o == lane_q[LANE_HI]));
endmodule

// File: tb/byte_word_bridge_test.sv
module byte_word_bridge_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_load_ni = 1'b1;
  logic [15:0] word_i = '0;
  logic        wr_lo_i = 1'b0, wr_hi_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        rd_lo_ni = 1'b1, rd_hi_ni = 1'b1;
  logic [7:0]  byte_o;
  logic        byte_oe_o, rd_conflict_o;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  byte_word_bridge uut (
    .clk_i(clk), .rst_ni(rst_ni), .word_load_ni(word_load_ni), .word_i(word_i),
    .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .byte_i(byte_i),
    .rd_lo_ni(rd_lo_ni), .rd_hi_ni(rd_hi_ni),
    .byte_o(byte_o), .byte_oe_o(byte_oe_o), .rd_conflict_o(rd_conflict_o));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one clock edge with given strobes; inputs change on negedge
  task automatic edge_op(input logic ld, input logic [15:0] w, input logic wl,
                         input logic wh, input logic [7:0] b);
    @(negedge clk);
    word_load_ni = ~ld; word_i = w; wr_lo_i = wl; wr_hi_i = wh; byte_i = b;
    @(negedge clk);
    word_load_ni = 1'b1; wr_lo_i = 1'b0; wr_hi_i = 1'b0;
    word_i = ~w; byte_i = ~b;
  endtask

  // little-endian read: low lane on first cycle, high lane on second
  task automatic read_word(input string req, input logic [15:0] exp);
    @(negedge clk); rd_lo_ni = 1'b0; rd_hi_ni = 1'b1; #1;
    chk(req, {7'd0, byte_oe_o, byte_o}, {8'h01, exp[7:0]});
    @(negedge clk); rd_lo_ni = 1'b1; rd_hi_ni = 1'b0; #1;
    chk(req, {7'd0, byte_oe_o, byte_o}, {8'h01, exp[15:8]});
    @(negedge clk); rd_lo_ni = 1'b1; rd_hi_ni = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] model;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    read_word("R1", 16'h0000);
    // R7 released bus
    @(negedge clk); #1;
    chk("R7", {13'd0, byte_oe_o, rd_conflict_o, |byte_o}, 16'h0000);

    // R2 word loads sweep
    for (int i = 0; i < 256; i++) begin
      model = 16'((i * 16'h0101) ^ 16'hA53C ^ (i << 7));
      edge_op(1'b1, model, 1'b0, 1'b0, 8'h00);
      read_word("R2", model);
    end

    // R3/R4 byte writes over all byte values, with R10 hold checks between
    model = 16'h1234;
    edge_op(1'b1, model, 1'b0, 1'b0, 8'h00);
    for (int v = 0; v < 256; v++) begin
      edge_op(1'b0, 16'hFFFF, 1'b1, 1'b0, 8'(v));
      model[7:0] = 8'(v);
      read_word("R3", model);
      edge_op(1'b0, 16'hFFFF, 1'b0, 1'b1, 8'(255 - v));
      model[15:8] = 8'(255 - v);
      read_word("R4", model);
      edge_op(1'b0, 16'hFFFF, 1'b0, 1'b0, 8'(v ^ 8'h5A));
      read_word("R10", model);
    end

    // R11 little-endian two-cycle fill then drain
    for (int k = 0; k < 64; k++) begin
      model = 16'(k * 1031 + 7);
      edge_op(1'b0, 16'h0000, 1'b1, 1'b0, model[7:0]);
      edge_op(1'b0, 16'h0000, 1'b0, 1'b1, model[15:8]);
      read_word("R11", model);
    end

    // R9 load beats byte writes
    for (int k = 0; k < 4; k++) begin
      model = 16'hC3A0 + 16'(k);
      edge_op(1'b1, model, k[0], k[1] | (k == 0), 8'h77);
      read_word("R9", model);
    end

    // R5/R6 lane reads, R8 conflict
    model = 16'hBEEF;
    edge_op(1'b1, model, 1'b0, 1'b0, 8'h00);
    @(negedge clk); rd_lo_ni = 1'b0; rd_hi_ni = 1'b1; #1;
    chk("R5", {7'd0, byte_oe_o, byte_o}, 16'h01EF);
    @(negedge clk); rd_lo_ni = 1'b1; rd_hi_ni = 1'b0; #1;
    chk("R6", {7'd0, byte_oe_o, byte_o}, 16'h01BE);
    @(negedge clk); rd_lo_ni = 1'b0; rd_hi_ni = 1'b0; #1;
    chk("R8", {6'd0, rd_conflict_o, byte_oe_o, byte_o}, 16'h0200);
    @(negedge clk); rd_lo_ni = 1'b1; rd_hi_ni = 1'b1; #1;
    chk("R7", {6'd0, rd_conflict_o, byte_oe_o, byte_o}, 16'h0000);
    read_word("R8", model);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule